// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit gathers the event pulses of an SD host controller into a latched status word and folds them into a single active-low interrupt line. Eight event sources are tracked: command complete, command timeout, response CRC error, read-block ready, write-block request, data transfer end, card inserted and card removed. Each source has a bit in a mask register. A set mask bit keeps that source from reaching the interrupt line. After reset every source is masked.

Software reads the status word through a small register port. It clears individual events by writing zeros to the bits it wants cleared. Bits written as one keep their value. An event that arrives in the same cycle as its clear wins, so no event is lost. Two live levels share the status word with the latched events: command busy and card write protect. They follow their inputs directly and are never latched or cleared. Software normally acknowledges events and reads status again until nothing unmasked is pending.

Top module: `sdh_irq_unit`

## Requirements
- R1: After reset, all latched event bits read 0, the mask reads 0x000000FF (every source masked), and `irq_n` is 1.
- R2: A 1 on `evt_in[i]` sets status bit i at that clock edge. The bit then stays set until software clears it.
- R3: A write to the status register (`reg_sel`=0) clears each event bit whose write-data bit is 0. Each event bit whose write-data bit is 1 keeps its value.
- R4: If an event pulse and a zero-write to the same status bit happen in the same cycle, the bit ends up set.
- R5: `irq_n` is registered. At each clock edge it becomes 0 if, just before that edge, some event bit was set with its mask bit at 0. Otherwise it becomes 1. A mask bit of 1 suppresses its source.
- R6: Status bit 16 reads `cmd_busy_i` and status bit 17 reads `wr_prot_i`. Both follow their inputs in the same cycle, with no latching, and status writes do not affect them.
- R7: The status bit order is: 0 command complete, 1 command timeout, 2 CRC error, 3 read ready, 4 write request, 5 data end, 6 card inserted, 7 card removed. Bits 8 to 15 and 18 to 31 read 0.
- R8: Card inserted and card removed are separate bits, and a single status write with both bits 0 clears both.
- R9: A write to the mask register (`reg_sel`=1) loads bits 7:0. Mask bits 31:8 read 0 whatever was written.
- R10: A mask write leaves every status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 8 | Event pulses, one bit per source |
| cmd_busy_i | input | 1 | Live command busy level |
| wr_prot_i | input | 1 | Live write protect level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mask (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
An event or a status or mask write changes `reg_rdata` at the clock edge that captures it. The live bits 16 and 17 change in the same cycle as their inputs. `irq_n` lags the status and mask by exactly one edge. The driver applies one operation per cycle at the falling edge. It queues the read data expected after the next rising edge, and also the interrupt level that follows from the status and mask just before that edge. The monitor compares both 1 ns after each rising edge, while the inputs are still held.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int WORD_W   = 32;
  localparam int EVT_N    = 8;
  localparam int BUSY_POS = 16;
  localparam int WP_POS   = 17;

  // event bit index order
  localparam int EV_CMD_DONE = 0;
  localparam int EV_CMD_TO   = 1;
  localparam int EV_CRC_ERR  = 2;
  localparam int EV_RD_RDY   = 3;
  localparam int EV_WR_REQ   = 4;
  localparam int EV_DAT_END  = 5;
  localparam int EV_CARD_IN  = 6;
  localparam int EV_CARD_OUT = 7;

  // next value of one latched event bit: set beats clear
  function automatic logic evt_next(logic cur, logic wr, logic keep, logic set);
    return set | (cur & (~wr | keep));
  endfunction

  // any source pending and not suppressed
  function automatic logic pending_any(logic [EVT_N-1:0] st, logic [EVT_N-1:0] mk,
                                       logic [EVT_N-1:0] cap);
    return |(st & cap & ~mk);
  endfunction
endpackage

// File: rtl/sdh_irq_status.sv
module sdh_irq_status #(
  parameter int EVT_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_set,
  input  logic             ack_we,
  input  logic [EVT_N-1:0] ack_keep,
  output logic [EVT_N-1:0] status_q
);
  import sdh_irq_pkg::*;

  for (genvar i = 0; i < EVT_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= evt_next(status_q[i], ack_we, ack_keep[i], evt_set[i]);
    end
  end
endmodule

// File: rtl/sdh_irq_mask.sv
module sdh_irq_mask #(
  parameter int EVT_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [EVT_N-1:0] wdata,
  output logic [EVT_N-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (we) mask_q <= wdata;
  end
endmodule

// File: rtl/sdh_irq_line.sv
module sdh_irq_line #(
  parameter int               EVT_N = 8,
  parameter logic [EVT_N-1:0] CAP   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] status_q,
  input  logic [EVT_N-1:0] mask_q,
  output logic             pend_now,
  output logic             irq_n
);
  import sdh_irq_pkg::*;

  assign pend_now = pending_any(status_q, mask_q, CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~pend_now;
  end
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit #(
  parameter int                                EVT_N = sdh_irq_pkg::EVT_N,
  parameter logic [sdh_irq_pkg::EVT_N-1:0]     CAP   = '1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [EVT_N-1:0]              evt_in,
  input  logic                          cmd_busy_i,
  input  logic                          wr_prot_i,
  input  logic                          reg_wr,
  input  logic                          reg_sel,
  input  logic [sdh_irq_pkg::WORD_W-1:0] reg_wdata,
  output logic [sdh_irq_pkg::WORD_W-1:0] reg_rdata,
  output logic                          irq_n
);
  import sdh_irq_pkg::*;

  logic             st_wr;
  logic             mk_wr;
  logic             pend_now;
  logic [EVT_N-1:0] status_q;
  logic [EVT_N-1:0] mask_q;
  logic [WORD_W-1:0] status_word;
  logic [WORD_W-1:0] mask_word;

  assign st_wr = reg_wr & ~reg_sel;
  assign mk_wr = reg_wr &  reg_sel;

  sdh_irq_status #(.EVT_N(EVT_N)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_in), .ack_we(st_wr),
    .ack_keep(reg_wdata[EVT_N-1:0]), .status_q(status_q)
  );

  sdh_irq_mask #(.EVT_N(EVT_N)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mk_wr), .wdata(reg_wdata[EVT_N-1:0]), .mask_q(mask_q)
  );

  sdh_irq_line #(.EVT_N(EVT_N), .CAP(CAP)) u_line (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q),
    .pend_now(pend_now), .irq_n(irq_n)
  );

  always_comb begin
    status_word              = '0;
    status_word[EVT_N-1:0]   = status_q;
    status_word[BUSY_POS]    = cmd_busy_i;
    status_word[WP_POS]      = wr_prot_i;
    mask_word                = '0;
    mask_word[EVT_N-1:0]     = mask_q;
  end

  assign reg_rdata = reg_sel ? mask_word : status_word;
endmodule

// File: rtl/sdh_irq_unit_chk.sv
module sdh_irq_unit_chk #(
  parameter int               EVT_N = 8,
  parameter logic [EVT_N-1:0] CAP   = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_N-1:0] evt_in,
  input logic             cmd_busy_i,
  input logic             wr_prot_i,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             irq_n,
  input logic [EVT_N-1:0] status_q,
  input logic [EVT_N-1:0] mask_q
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_in)) == $past(evt_in)));  // R4

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=>
      ((status_q & ~$past(reg_wdata[EVT_N-1:0]) & ~$past(evt_in)) == '0));  // R3

  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=>
      ((status_q & $past(reg_wdata[EVT_N-1:0]) & $past(status_q)) ==
       ($past(reg_wdata[EVT_N-1:0]) & $past(status_q))));  // R3

  AST_EVT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || reg_sel) |=> ((status_q & $past(status_q)) == $past(status_q)));  // R2

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !$past(|(status_q & CAP & ~mask_q))));  // R5

  AST_LIVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[16] == cmd_busy_i && reg_rdata[17] == wr_prot_i));  // R6

  AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[31:EVT_N] == '0));  // R9
endmodule

bind sdh_irq_unit sdh_irq_unit_chk #(.EVT_N(EVT_N), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cmd_busy_i(cmd_busy_i),
  .wr_prot_i(wr_prot_i), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_n(irq_n), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/sdh_irq_unit_test.sv
`timescale 1ns/1ps
module sdh_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_in = '0;
  logic        cmd_busy_i = 1'b0;
  logic        wr_prot_i = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;

  always #2 clk = ~clk;

  sdh_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cmd_busy_i(cmd_busy_i),
    .wr_prot_i(wr_prot_i), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;

  // reference state
  logic [7:0] m_st = 8'h00;
  logic [7:0] m_mk = 8'hFF;
  logic       m_irq = 1'b1;

  task automatic step(input logic [7:0] ev, input logic wr, input logic sel,
                      input logic [31:0] wd, input logic busy, input logic wp,
                      input string tag);
    exp_t e;
    @(negedge clk);
    evt_in = ev; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    cmd_busy_i = busy; wr_prot_i = wp;
    m_irq = (m_st & ~m_mk) == 8'h00;
    if (wr && !sel) m_st = m_st & wd[7:0];
    if (wr && sel)  m_mk = wd[7:0];
    m_st = m_st | ev;
    e.rdata = sel ? {24'h0, m_mk} : {14'h0, wp, busy, 8'h00, m_st};
    e.irq   = m_irq;
    e.tag   = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (reg_rdata !== e.rdata || irq_n !== e.irq) begin
          n_errors++;
          $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
                   e.tag, reg_rdata, irq_n, e.rdata, e.irq);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(8'h00, 0, 0, 32'h0, 0, 0, "R1 status after reset");
    step(8'h00, 0, 1, 32'h0, 0, 0, "R1 mask after reset");
    step(8'h01, 0, 0, 32'h0, 0, 0, "R2 event sets bit0, masked");
    step(8'h00, 0, 0, 32'h0, 0, 0, "R2 bit holds, R5 masked keeps irq high");
    step(8'h00, 1, 1, 32'hFFFF_FFFE, 0, 0, "R9 mask write upper bits drop");
    step(8'h00, 0, 0, 32'h0, 0, 0, "R10 mask write kept status, R5 irq low");
    step(8'h00, 1, 0, 32'hFFFF_FFFE, 0, 0, "R3 zero clears bit0");
    step(8'h00, 0, 0, 32'h0, 0, 0, "R5 irq returns high");
    step(8'h48, 0, 0, 32'h0, 0, 0, "R7 read ready and card inserted");
    step(8'h08, 1, 0, 32'hFFFF_FFF7, 0, 0, "R4 set beats clear bit3");
    step(8'h00, 1, 0, 32'hFFFF_FFFF, 0, 0, "R3 ones keep bits");
    step(8'h80, 0, 0, 32'h0, 0, 0, "R8 card removed separate bit");
    step(8'h00, 1, 0, 32'hFFFF_FF3F, 0, 0, "R8 both card bits cleared");
    step(8'h00, 0, 0, 32'h0, 1, 0, "R6 busy live");
    step(8'h00, 1, 0, 32'h0000_0000, 1, 1, "R6 live bits survive write");
    step(8'h00, 0, 0, 32'h0, 0, 1, "R6 busy drops at once");
    step(8'h20, 0, 0, 32'h0, 0, 0, "R7 data end bit5");
    step(8'h00, 1, 1, 32'h0000_00DF, 0, 0, "R5 unmask data end");
    step(8'h00, 0, 0, 32'h0, 0, 0, "R5 irq low for data end");
    step(8'h00, 1, 1, 32'h0000_00FF, 0, 0, "R5 remask");
    step(8'h00, 0, 0, 32'h0, 0, 0, "R5 irq high after remask");
    step(8'h00, 0, 0, 32'h0, 0, 0, "R7 reserved bits zero");
    @(negedge clk);
    reg_wr = 0; evt_in = '0;
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule